// File: doc/BRIEF.md
# Store Buffer with Read Bypass

This block sits between a write-through cache and the memory controller. Every store the processor performs is also pushed into a small first-in, first-out queue of address/data pairs. The memory side pulls entries out one at a time, oldest first, through a valid/ready write port. Stores that arrive in bursts fill the queue, and the store port stalls the producer when no slot is free.

The queue may hold the only up-to-date copy of a location, so it also screens read misses. A read lookup address is compared against every queued entry at once. In bypass mode a match answers the read straight from the queue, using the youngest matching entry. A store presented in the same cycle as the lookup counts as the youngest of all. A read that matches nothing goes to memory through a separate request port. While that request is being offered, draining is held off so the read reaches memory ahead of the queued writes. With the conservative mode input set, no read is answered from the queue. The read instead waits until the queue has fully drained, with the store port closed meanwhile, and is then sent to memory.

Only one read is in flight at a time. The read port accepts a new lookup only when the previous one has been answered, or in the same cycle that its answer is driven.

Top module: `store_buffer_fwd`

## Requirements
- R1: After reset the queue is empty. `st_ready` and `rd_ready` are 1, and `mw_valid`, `mr_valid` and `rd_resp_valid` are 0.
- R2: Entries leave on the memory write port in the exact order they were accepted, one per `mw_valid`/`mw_ready` handshake. `mw_valid` is 0 whenever the queue is empty.
- R3: The queue holds DEPTH (default 4) entries. When it is full, `st_ready` is 0, and a store offered while full is not taken and never appears on the memory write port.
- R4: In bypass mode (`hold_mode` = 0), a lookup whose address matches a queued entry gets `rd_resp_valid` = 1 with that entry's data in the cycle after the lookup is accepted, and no memory read is issued.
- R5: When several queued entries match the lookup address, the data returned is that of the most recently accepted one.
- R6: A store accepted in the same cycle as a lookup to the same address is treated as the youngest entry, so its data is returned.
- R7: A lookup that matches nothing raises `mr_valid` with `mr_addr` equal to the lookup address in the next cycle. It holds both until `mr_ready`. It returns `mr_resp_data` on `rd_resp_data` one cycle after `mr_resp_valid`.
- R8: While `mr_valid` is 1, `mw_valid` is 0.
- R9: In conservative mode (`hold_mode` = 1), a lookup is never answered from the queue. If the queue is not empty, `st_ready` stays 0 until it has drained. `mr_valid` rises only once the queue is empty, so the answer is the value memory holds after all queued writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_mode | input | 1 | 1 = conservative mode (drain before reading), 0 = bypass mode |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read lookup offered |
| rd_ready | output | 1 | Lookup can be accepted |
| rd_addr | input | ADDR_W | Lookup address |
| rd_resp_valid | output | 1 | One-cycle pulse with lookup answer |
| rd_resp_data | output | DATA_W | Lookup answer data |
| mw_valid | output | 1 | Oldest entry offered to memory |
| mw_ready | input | 1 | Memory takes the offered entry |
| mw_addr | output | ADDR_W | Address of the oldest entry |
| mw_data | output | DATA_W | Data of the oldest entry |
| mr_valid | output | 1 | Memory read request |
| mr_ready | input | 1 | Memory takes the read request |
| mr_addr | output | ADDR_W | Memory read address |
| mr_resp_valid | input | 1 | Memory read data returned |
| mr_resp_data | input | DATA_W | Memory read data |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose. In the first, a store and a lookup to an address the queue already holds are driven in one cycle. The bench judges the case by the answer: the new store's data must come back one cycle later with no memory read. In the second, a read miss is raised while entries are waiting to drain. The bench samples the cycle after acceptance and requires `mr_valid` high, the lookup address on `mr_addr`, and `mw_valid` low. In conservative mode, the bench records how many drains had completed when the memory read was taken, and requires that number to include every entry that was queued.

// File: rtl/wbf_pkg.sv
`timescale 1ns/1ps
package wbf_pkg;
  // Read-side sequencing states
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,  // ready for a lookup
    RD_HOLD  = 2'd1,  // conservative mode: waiting for the queue to empty
    RD_ISSUE = 2'd2,  // memory read request offered
    RD_WAIT  = 2'd3   // waiting for memory read data
  } rd_state_t;
endpackage

// File: rtl/wbf_queue.sv
`timescale 1ns/1ps
module wbf_queue #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [ADDR_W-1:0]         push_addr,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      pop,
  output logic [ADDR_W-1:0]         head_addr,
  output logic [DATA_W-1:0]         head_data,
  output logic [$clog2(DEPTH)-1:0]  head_ptr,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [DEPTH*ADDR_W-1:0]   ent_addr,
  output logic [DEPTH*DATA_W-1:0]   ent_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] a_mem [DEPTH];
  logic [DATA_W-1:0] d_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  // Storage is written without reset; slots are only read once written.
  always_ff @(posedge clk) begin
    if (push) begin
      a_mem[wr_ptr] <= push_addr;
      d_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_ptr  = rd_ptr;
  assign head_addr = a_mem[rd_ptr];
  assign head_data = d_mem[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign ent_addr[g*ADDR_W +: ADDR_W] = a_mem[g];
    assign ent_data[g*DATA_W +: DATA_W] = d_mem[g];
  end
endmodule

// File: rtl/wbf_match.sv
`timescale 1ns/1ps
module wbf_match #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic [DEPTH*ADDR_W-1:0]    ent_addr,
  input  logic [DEPTH*DATA_W-1:0]    ent_data,
  input  logic [$clog2(DEPTH)-1:0]   head_ptr,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [ADDR_W-1:0]          look_addr,
  output logic                       hit,
  output logic [DATA_W-1:0]          hit_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0] eq;

  // One comparator per physical slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = (ent_addr[g*ADDR_W +: ADDR_W] == look_addr);
  end

  // Walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    logic [PTR_W-1:0] slot;
    hit      = 1'b0;
    hit_data = '0;
    slot     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_ptr + PTR_W'(k);
      if ((CNT_W'(k) < count) && eq[slot]) begin
        hit      = 1'b1;
        hit_data = ent_data[slot*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wbf_rd_ctrl.sv
`timescale 1ns/1ps
module wbf_rd_ctrl
  import wbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_mode,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              buf_empty,
  input  logic              st_fire,
  input  logic              byp_hit,
  input  logic [DATA_W-1:0] byp_data,
  input  logic              mr_ready,
  input  logic              mr_resp_valid,
  input  logic [DATA_W-1:0] mr_resp_data,
  output logic              rd_ready,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mr_valid,
  output logic [ADDR_W-1:0] mr_addr,
  output logic              store_block,
  output logic              drain_pause
);
  rd_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RD_IDLE;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
      mr_valid      <= 1'b0;
      mr_addr       <= '0;
    end else begin
      rd_resp_valid <= 1'b0;
      case (state)
        RD_IDLE: begin
          if (rd_valid) begin
            mr_addr <= rd_addr;
            if (!hold_mode && byp_hit) begin
              rd_resp_valid <= 1'b1;
              rd_resp_data  <= byp_data;
            end else if (hold_mode && (!buf_empty || st_fire)) begin
              state <= RD_HOLD;
            end else begin
              state    <= RD_ISSUE;
              mr_valid <= 1'b1;
            end
          end
        end
        RD_HOLD: begin
          if (buf_empty) begin
            state    <= RD_ISSUE;
            mr_valid <= 1'b1;
          end
        end
        RD_ISSUE: begin
          if (mr_ready) begin
            state    <= RD_WAIT;
            mr_valid <= 1'b0;
          end
        end
        RD_WAIT: begin
          if (mr_resp_valid) begin
            state         <= RD_IDLE;
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= mr_resp_data;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign rd_ready    = (state == RD_IDLE);
  assign store_block = (state == RD_HOLD);
  assign drain_pause = (state == RD_ISSUE);
endmodule

// File: rtl/store_buffer_fwd.sv
`timescale 1ns/1ps
module store_buffer_fwd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_mode,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0] mw_data,
  output logic              mr_valid,
  input  logic              mr_ready,
  output logic [ADDR_W-1:0] mr_addr,
  input  logic              mr_resp_valid,
  input  logic [DATA_W-1:0] mr_resp_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0]        head_ptr;
  logic [CNT_W-1:0]        count;
  logic [DEPTH*ADDR_W-1:0] ent_addr;
  logic [DEPTH*DATA_W-1:0] ent_data;
  logic                    q_hit;
  logic [DATA_W-1:0]       q_data;
  logic                    st_fire;
  logic                    pop;
  logic                    byp_hit;
  logic [DATA_W-1:0]       byp_data;
  logic                    store_block;
  logic                    drain_pause;
  logic                    new_hit;

  assign st_ready = (count != FULL_CNT) && !store_block;
  assign st_fire  = st_valid && st_ready;
  assign mw_valid = (count != '0) && !drain_pause;
  assign pop      = mw_valid && mw_ready;

  // A store accepted this cycle is younger than anything queued
  assign new_hit  = st_fire && (st_addr == rd_addr);
  assign byp_hit  = new_hit || q_hit;
  assign byp_data = new_hit ? st_data : q_data;

  wbf_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (st_fire),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (pop),
    .head_addr (mw_addr),
    .head_data (mw_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  wbf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .look_addr (rd_addr),
    .hit       (q_hit),
    .hit_data  (q_data)
  );

  wbf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdctl (
    .clk           (clk),
    .rst           (rst),
    .hold_mode     (hold_mode),
    .rd_valid      (rd_valid),
    .rd_addr       (rd_addr),
    .buf_empty     (count == '0),
    .st_fire       (st_fire),
    .byp_hit       (byp_hit),
    .byp_data      (byp_data),
    .mr_ready      (mr_ready),
    .mr_resp_valid (mr_resp_valid),
    .mr_resp_data  (mr_resp_data),
    .rd_ready      (rd_ready),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_data  (rd_resp_data),
    .mr_valid      (mr_valid),
    .mr_addr       (mr_addr),
    .store_block   (store_block),
    .drain_pause   (drain_pause)
  );
endmodule

// File: rtl/wbf_checker.sv
`timescale 1ns/1ps
module wbf_checker #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_mode,
  input logic              st_valid,
  input logic              st_ready,
  input logic              rd_ready,
  input logic              rd_resp_valid,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic              mr_valid,
  input logic              mr_ready,
  input logic [ADDR_W-1:0] mr_addr
);
  localparam int OCC_W = $clog2(DEPTH+1) + 1;

  // Occupancy rebuilt from port handshakes only
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + OCC_W'(st_valid && st_ready) - OCC_W'(mw_valid && mw_ready);
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) |-> !st_ready);
  assert_empty_no_drain_R2: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !mw_valid);
  assert_drain_paused_R8: assert property (@(posedge clk) disable iff (rst)
    mr_valid |-> !mw_valid);
  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (mr_valid && !mr_ready) |=> (mr_valid && $stable(mr_addr)));
  assert_answer_idle_R4: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid |-> rd_ready);
  assert_hold_empty_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(mr_valid) && $past(hold_mode)) |-> (occ == '0));
endmodule

bind store_buffer_fwd wbf_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .hold_mode     (hold_mode),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .rd_ready      (rd_ready),
  .rd_resp_valid (rd_resp_valid),
  .mw_valid      (mw_valid),
  .mw_ready      (mw_ready),
  .mr_valid      (mr_valid),
  .mr_ready      (mr_ready),
  .mr_addr       (mr_addr)
);

// File: tb/tb_store_buffer_fwd.sv
`timescale 1ns/1ps
module tb_store_buffer_fwd;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int DEP = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          hold_mode = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_resp_valid;
  logic [DW-1:0] rd_resp_data;
  logic          mw_valid;
  logic          mw_ready;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;
  logic          mr_valid;
  logic          mr_ready = 1'b1;
  logic [AW-1:0] mr_addr;
  logic          mr_resp_valid = 1'b0;
  logic [DW-1:0] mr_resp_data = '0;

  logic mw_rdy_cfg = 1'b0;
  assign mw_ready = mw_rdy_cfg;

  store_buffer_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .hold_mode(hold_mode),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mr_resp_valid(mr_resp_valid), .mr_resp_data(mr_resp_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Memory model and logs
  logic [DW-1:0] mem_model [256];
  logic [AW-1:0] dlog_a [64];
  logic [DW-1:0] dlog_d [64];
  int dcnt = 0;
  int mr_cnt = 0;
  int mr_drained_at = 0;
  int pend = 0;
  logic [AW-1:0] pend_a = '0;

  initial for (int i = 0; i < 256; i++) mem_model[i] = 16'hC300 | 16'(i);

  // Memory side, evaluated half a cycle before each rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (mw_valid && mw_ready) begin
        dlog_a[dcnt] = mw_addr;
        dlog_d[dcnt] = mw_data;
        mem_model[mw_addr] = mw_data;
        dcnt++;
      end
      mr_resp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mr_resp_valid = 1'b1;
          mr_resp_data  = mem_model[pend_a];
        end
      end
      if (mr_valid && mr_ready) begin
        pend = 3;
        pend_a = mr_addr;
        mr_cnt++;
        mr_drained_at = dcnt;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready) @(negedge clk);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat, output int mrs);
    int m0;
    m0 = mr_cnt;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1;
    rd_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rd_resp_valid && lat < 50);
    d = rd_resp_data;
    mrs = mr_cnt - m0;
  endtask

  task automatic set_drain(input bit on);
    @(posedge clk); #1;
    mw_rdy_cfg = on;
  endtask

  task automatic drain_all();
    set_drain(1'b1);
    repeat (10) @(negedge clk);
    set_drain(1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    int lat, mrs, base;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(st_ready == 1'b1 && rd_ready == 1'b1, "R1 ready", {st_ready, rd_ready}, 2'b11);
    check(!mw_valid && !mr_valid && !rd_resp_valid, "R1 valids", {mw_valid, mr_valid, rd_resp_valid}, 0);

    // R3 / R2: fill, overflow attempt, drain order
    base = dcnt;
    for (int i = 0; i < DEP; i++) push(8'h01 + 8'(i), 16'h1000 + 16'(i));
    @(negedge clk);
    check(st_ready == 1'b0, "R3 full stalls", st_ready, 0);
    st_valid = 1'b1; st_addr = 8'h05; st_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    check(st_ready == 1'b0, "R3 offered while full", st_ready, 0);
    st_valid = 1'b0;
    drain_all();
    check(dcnt - base == DEP, "R3 extra store dropped", dcnt - base, DEP);
    for (int i = 0; i < DEP; i++)
      check(dlog_a[base+i] == 8'h01 + 8'(i) && dlog_d[base+i] == 16'h1000 + 16'(i),
            "R2 drain order", {dlog_a[base+i], dlog_d[base+i]}, {8'h01 + 8'(i), 16'h1000 + 16'(i)});
    check(!mw_valid, "R2 empty no drain", mw_valid, 0);

    // R7 / R8: miss raised while entries wait to drain
    push(8'h50, 16'h5050);
    push(8'h51, 16'h5151);
    set_drain(1'b1);
    mw_rdy_cfg = 1'b0;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 8'h77;
    set_drain(1'b1);
    rd_valid = 1'b0;
    @(negedge clk);
    check(mr_valid == 1'b1 && mr_addr == 8'h77, "R7 request", {mr_valid, mr_addr}, {1'b1, 8'h77});
    check(mw_valid == 1'b0, "R8 drain paused", mw_valid, 0);
    lat = 0;
    while (!rd_resp_valid && lat < 30) begin @(negedge clk); lat++; end
    check(rd_resp_data == 16'hC377, "R7 miss data", rd_resp_data, 16'hC377);
    set_drain(1'b0);
    drain_all();

    // R4 / R7: sweep lookup addresses around a full queue
    for (int i = 0; i < DEP; i++) push(8'h10 + 8'(i), 16'h2000 + 16'((8'h10 + i) * 3));
    for (int a = 8'h0E; a <= 8'h15; a++) begin
      do_read(8'(a), d, lat, mrs);
      if (a >= 8'h10 && a <= 8'h13) begin
        check(d == 16'h2000 + 16'(a * 3), "R4 hit data", d, 16'h2000 + 16'(a * 3));
        check(lat == 1 && mrs == 0, "R4 hit timing", {lat[7:0], mrs[7:0]}, 16'h0100);
      end else begin
        check(d == (16'hC300 | 16'(a)), "R7 miss data", d, 16'hC300 | 16'(a));
        check(mrs == 1, "R7 one memory read", mrs, 1);
      end
    end
    drain_all();

    // R5: several matches, youngest wins
    push(8'h20, 16'hAAAA);
    push(8'h21, 16'hBBBB);
    push(8'h20, 16'hCCCC);
    push(8'h20, 16'hDDDD);
    do_read(8'h20, d, lat, mrs);
    check(d == 16'hDDDD && mrs == 0, "R5 youngest match", d, 16'hDDDD);
    do_read(8'h21, d, lat, mrs);
    check(d == 16'hBBBB, "R5 single match", d, 16'hBBBB);
    base = dcnt;
    drain_all();
    check(dlog_d[base+3] == 16'hDDDD && dlog_d[base+1] == 16'hBBBB, "R2 same-address order",
          dlog_d[base+3], 16'hDDDD);

    // R6: store and lookup to the same address in one cycle
    push(8'h30, 16'h1111);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 8'h30; st_data = 16'h2222;
    rd_valid = 1'b1; rd_addr = 8'h30;
    base = mr_cnt;
    @(posedge clk); #1;
    st_valid = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    check(rd_resp_valid && rd_resp_data == 16'h2222, "R6 same-cycle store", rd_resp_data, 16'h2222);
    check(mr_cnt == base, "R6 no memory read", mr_cnt - base, 0);
    drain_all();

    // R9: conservative mode
    hold_mode = 1'b1;
    push(8'h40, 16'h4444);
    push(8'h41, 16'h4545);
    base = dcnt;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 8'h40;
    @(posedge clk); #1;
    rd_valid = 1'b0;
    @(negedge clk);
    check(st_ready == 1'b0, "R9 store blocked", st_ready, 0);
    check(mr_valid == 1'b0 && rd_resp_valid == 1'b0, "R9 no forward", {mr_valid, rd_resp_valid}, 0);
    set_drain(1'b1);
    lat = 0;
    while (!rd_resp_valid && lat < 30) begin @(negedge clk); lat++; end
    check(rd_resp_data == 16'h4444, "R9 memory data", rd_resp_data, 16'h4444);
    check(mr_drained_at - base == 2, "R9 drained before read", mr_drained_at - base, 2);
    set_drain(1'b0);
    do_read(8'h41, d, lat, mrs);
    check(d == 16'h4545 && mrs == 1, "R9 empty queue read", d, 16'h4545);
    hold_mode = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule